// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Hours

This block keeps time of day and calendar date as seven packed-BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year that stands for 2000 to 2099. An internal prescaler divides the system clock by `TICKS_PER_SEC` to form a once-per-second step. Each step ripples carries up through the fields, taking account of month lengths and leap years.

The hour byte carries its own format. With bit 6 clear it is plain BCD 00 to 23. With bit 6 set it holds 1 to 12 in BCD, and bit 5 marks the afternoon. Counting is correct in either format, and the format bit is never changed by counting. A host loads one field per cycle through a select code and a data byte, and every field is always visible on its own output. A stop input halts time. Any field load restarts the prescaler, so the first step after a load comes one full second later.

Top module: `cal_bcd_clock`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x00 (24-hour midnight), weekday 0x01, day 0x01, month 0x01 and year 0x00.
- R2: While running, the time advances by exactly one second every `TICKS_PER_SEC` clock cycles. A field load restarts the count, so the next advance occurs `TICKS_PER_SEC` cycles after the load edge.
- R3: Seconds and minutes count 00 to 59 in BCD. Going from 59 to 00 carries into the next field.
- R4: With hour bit 6 clear, hours count 0x00 to 0x23. Going from 0x23 to 0x00 advances the date.
- R5: With hour bit 6 set, the hour sequence is 12 AM, 1 to 11 AM, 12 PM, then 1 to 11 PM. Bit 5 (PM) toggles on each step from 11 to 12, and the date advances only on the step from 11 PM to 12 AM. Bit 6 is never altered by counting.
- R6: The weekday counts 1 to 7 and wraps from 7 to 1 when the date advances.
- R7: The day wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12. It wraps after 30 in months 04, 06, 09 and 11, and this advances the month.
- R8: February (month 0x02) has 29 days when the year value is divisible by 4 (including 00), and 28 days otherwise.
- R9: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R10: While `osc_off` is 1, no field advances and the prescaler holds. Field loads still take effect.
- R11: A load with `wr_en` high writes `wr_data` into the selected field at the next edge. Select codes are 0 seconds, 1 minutes, 2 hour, 3 weekday, 4 day, 5 month and 6 year. Code 7 changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_off | input | 1 | Active-low time enable: 1 stops time |
| wr_en | input | 1 | Field load strobe |
| wr_sel | input | 3 | Field select code (R11) |
| wr_data | input | 8 | BCD value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte: bit 6 selects 12-hour mode, bit 5 PM, low bits BCD hour |
| wday_o | output | 8 | Weekday 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00 to 99, BCD |

## Verification
A corrupt carry chain shows at the ports within one second step. For example, a wrong month length or leap decision puts an impossible day such as 0x31 in month 0x04 on `date_o` at the step that should have wrapped. A wrong AM/PM step makes `hour_o` leave the legal 12-hour set or toggle bit 5 at the wrong hour. A prescaler that is off by even one cycle moves `sec_o` one cycle early or late relative to a load, and so it is caught at the first step after any write.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_DATE = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6,
    F_NONE = 3'd7
  } field_e;

  typedef struct packed {
    logic [BYTE_W-1:0] value;
    logic              carry;
  } step_t;

  // Increment a packed BCD byte (no wrap handling beyond digit carry).
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [BYTE_W-1:0] v);
    bcd_to_bin = 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // Last day of the month, as BCD, for years 2000..2099.
  function automatic logic [BYTE_W-1:0] month_len(input logic [BYTE_W-1:0] mon,
                                                  input logic [BYTE_W-1:0] yr);
    logic [6:0] ybin;
    ybin = bcd_to_bin(yr);
    case (mon)
      8'h02:                     month_len = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
      default:                   month_len = 8'h31;
    endcase
  endfunction

  // One step of the hour byte in either encoding; carry marks a new day.
  function automatic step_t hour_step(input logic [BYTE_W-1:0] hv);
    step_t r;
    logic [BYTE_W-1:0] low_inc;
    low_inc = bcd_inc({3'b000, hv[4:0]});
    if (hv[6]) begin
      if (hv[4:0] == 5'h11) begin
        r.value = {1'b0, 1'b1, ~hv[5], 5'h12};
        r.carry = hv[5];
      end else if (hv[4:0] == 5'h12) begin
        r.value = {1'b0, 1'b1, hv[5], 5'h01};
        r.carry = 1'b0;
      end else begin
        r.value = {1'b0, 1'b1, hv[5], low_inc[4:0]};
        r.carry = 1'b0;
      end
    end else begin
      if (hv == 8'h23) begin
        r.value = 8'h00;
        r.carry = 1'b1;
      end else begin
        r.value = bcd_inc(hv);
        r.carry = 1'b0;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign tick = run && !clear && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (tick)       cnt <= '0;
    else if (run)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cal_time_unit.sv
module cal_time_unit
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_hit,
  input  field_e            wr_field,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] sec,
  output logic [BYTE_W-1:0] min,
  output logic [BYTE_W-1:0] hour,
  output logic              sec_carry,
  output logic              min_carry,
  output logic              day_carry
);
  step_t hnext;

  assign hnext     = hour_step(hour);
  assign sec_carry = tick && (sec == 8'h59);
  assign min_carry = sec_carry && (min == 8'h59);
  assign day_carry = min_carry && hnext.carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
    end else begin
      if (wr_hit && wr_field == F_SEC)  sec <= wr_data;
      else if (tick)                    sec <= sec_carry ? 8'h00 : bcd_inc(sec);

      if (wr_hit && wr_field == F_MIN)  min <= wr_data;
      else if (sec_carry)               min <= min_carry ? 8'h00 : bcd_inc(min);

      if (wr_hit && wr_field == F_HOUR) hour <= wr_data;
      else if (min_carry)               hour <= hnext.value;
    end
  end
endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_carry,
  input  logic              wr_hit,
  input  field_e            wr_field,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] wday,
  output logic [BYTE_W-1:0] date,
  output logic [BYTE_W-1:0] month,
  output logic [BYTE_W-1:0] year,
  output logic              date_carry,
  output logic              month_carry
);
  logic [BYTE_W-1:0] last_day;

  assign last_day    = month_len(month, year);
  assign date_carry  = day_carry && (date == last_day);
  assign month_carry = date_carry && (month == 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday  <= 8'h01;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else begin
      if (wr_hit && wr_field == F_WDAY) wday <= wr_data;
      else if (day_carry)               wday <= (wday == 8'h07) ? 8'h01 : bcd_inc(wday);

      if (wr_hit && wr_field == F_DATE) date <= wr_data;
      else if (day_carry)               date <= date_carry ? 8'h01 : bcd_inc(date);

      if (wr_hit && wr_field == F_MON)  month <= wr_data;
      else if (date_carry)              month <= month_carry ? 8'h01 : bcd_inc(month);

      if (wr_hit && wr_field == F_YEAR) year <= wr_data;
      else if (month_carry)             year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end
endmodule

// File: rtl/cal_bcd_clock.sv
module cal_bcd_clock
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_off,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  field_e wr_field;
  logic   write_hit;
  logic   tick;
  logic   sec_carry, min_carry, day_carry, date_carry, month_carry;

  assign wr_field  = field_e'(wr_sel);
  assign write_hit = wr_en && (wr_field != F_NONE);

  cal_prescaler #(.TICKS(TICKS_PER_SEC)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!osc_off),
    .clear (write_hit),
    .tick  (tick)
  );

  cal_time_unit u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_hit    (write_hit),
    .wr_field  (wr_field),
    .wr_data   (wr_data),
    .sec       (sec_o),
    .min       (min_o),
    .hour      (hour_o),
    .sec_carry (sec_carry),
    .min_carry (min_carry),
    .day_carry (day_carry)
  );

  cal_date_unit u_date (
    .clk         (clk),
    .rst_n       (rst_n),
    .day_carry   (day_carry),
    .wr_hit      (write_hit),
    .wr_field    (wr_field),
    .wr_data     (wr_data),
    .wday        (wday_o),
    .date        (date_o),
    .month       (month_o),
    .year        (year_o),
    .date_carry  (date_carry),
    .month_carry (month_carry)
  );
endmodule

// File: rtl/cal_bcd_clock_chk.sv
module cal_bcd_clock_chk #(
  parameter int TICKS_PER_SEC = 32768
) (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_off,
  input logic       write_hit,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       tick,
  input logic       sec_carry,
  input logic       day_carry,
  input logic       month_carry,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);
  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap <= 0;
    else if (write_hit) gap <= 0;
    else if (tick)      gap <= 0;
    else if (!osc_off)  gap <= gap + 1;
  end

  // R2
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap == TICKS_PER_SEC - 1));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_carry && !write_hit) |=> (sec_o == 8'h00));

  // R3
  sec_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (sec_o != $past(sec_o)));

  // R4
  midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !hour_o[6]) |=> (hour_o == 8'h00));

  // R5
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(write_hit && wr_sel == 3'd2) |=> (hour_o[6] == $past(hour_o[6])));

  // R6
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && wday_o == 8'h07) |=> (wday_o == 8'h01));

  // R9
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (month_carry && year_o == 8'h99) |=> (year_o == 8'h00));

  // R10
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !write_hit) |=>
      $stable({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o}));

  // R11
  load_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (write_hit && wr_sel == 3'd0) |=> (sec_o == $past(wr_data)));
endmodule

bind cal_bcd_clock cal_bcd_clock_chk #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .osc_off     (osc_off),
  .write_hit   (write_hit),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .tick        (tick),
  .sec_carry   (sec_carry),
  .day_carry   (day_carry),
  .month_carry (month_carry),
  .sec_o       (sec_o),
  .min_o       (min_o),
  .hour_o      (hour_o),
  .wday_o      (wday_o),
  .date_o      (date_o),
  .month_o     (month_o),
  .year_o      (year_o)
);

// File: tb/sim_cal_bcd_clock.sv
module sim_cal_bcd_clock;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;

  typedef struct {
    int s, m, h, wd, d, mo, y;
    bit h12;
  } tm_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_off = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cal_bcd_clock #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_off(osc_off), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .wday_o(wday_o), .date_o(date_o), .month_o(month_o),
    .year_o(year_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_of(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_byte(tm_t t);
    int hr;
    if (!t.h12) return to_bcd(t.h);
    hr = t.h % 12;
    if (hr == 0) hr = 12;
    return 8'h40 | (t.h >= 12 ? 8'h20 : 8'h00) | to_bcd(hr);
  endfunction

  function automatic logic [55:0] pack_tm(tm_t t);
    return {to_bcd(t.s), to_bcd(t.m), hour_byte(t), to_bcd(t.wd),
            to_bcd(t.d), to_bcd(t.mo), to_bcd(t.y)};
  endfunction

  function automatic tm_t advance(tm_t t, int n);
    for (int i = 0; i < n; i++) begin
      t.s++;
      if (t.s == 60) begin t.s = 0; t.m++; end
      if (t.m == 60) begin
        t.m = 0; t.h++;
        if (t.h == 24) begin
          t.h = 0;
          t.wd = (t.wd == 7) ? 1 : t.wd + 1;
          t.d++;
          if (t.d > days_of(t.mo, t.y)) begin
            t.d = 1; t.mo++;
            if (t.mo == 13) begin t.mo = 1; t.y = (t.y + 1) % 100; end
          end
        end
      end
    end
    return t;
  endfunction

  function automatic logic [55:0] outs();
    return {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};
  endfunction

  task automatic check(string req, logic [55:0] got, logic [55:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_all(tm_t t);
    logic [55:0] v;
    v = pack_tm(t);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_sel = 3'(k);
      wr_data = v[55 - 8*k -: 8];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_secs(int n);
    repeat (n * TPS) @(negedge clk);
  endtask

  task automatic directed(string req, tm_t t, int n);
    load_all(t);
    run_secs(n);
    check(req, outs(), pack_tm(advance(t, n)));
  endtask

  function automatic tm_t mk(int s, int m, int h, bit h12, int wd, int d, int mo, int y);
    tm_t t;
    t.s = s; t.m = m; t.h = h; t.h12 = h12; t.wd = wd; t.d = d; t.mo = mo; t.y = y;
    return t;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tm_t t;
    void'($urandom(32'd1305));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", outs(), 56'h00_00_00_01_01_01_00);

    // R2 first step after a load comes exactly one second later
    t = mk(10, 0, 5, 0, 3, 10, 6, 21);
    load_all(t);
    repeat (TPS - 1) @(negedge clk);
    check("R2 before step", outs(), pack_tm(t));
    @(negedge clk);
    check("R2 at step", outs(), pack_tm(advance(t, 1)));
    // R2 a load mid-second restarts the prescaler
    t = advance(t, 1);
    repeat (2) @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h40;
    @(negedge clk); wr_en = 1'b0;
    t.s = 40;
    repeat (TPS - 1) @(negedge clk);
    check("R2 restart hold", outs(), pack_tm(t));
    @(negedge clk);
    check("R2 restart step", outs(), pack_tm(advance(t, 1)));

    // R3 R4 R6 R7 R9 end of year, Sunday wrap
    directed("R9 year end", mk(58, 59, 23, 0, 7, 31, 12, 37), 3);
    directed("R9 century", mk(59, 59, 23, 0, 2, 31, 12, 99), 2);
    directed("R3 minute", mk(57, 14, 9, 0, 1, 5, 5, 5), 4);
    directed("R4 midnight", mk(59, 59, 23, 0, 4, 12, 3, 12), 1);
    directed("R7 thirty", mk(59, 59, 23, 0, 2, 30, 4, 10), 1);
    directed("R7 thirtyone", mk(59, 59, 23, 0, 2, 30, 7, 10), 1);
    directed("R8 feb common", mk(59, 59, 23, 0, 2, 28, 2, 23), 1);
    directed("R8 feb leap", mk(59, 59, 23, 0, 2, 28, 2, 24), 1);
    directed("R8 feb 29", mk(59, 59, 23, 0, 2, 29, 2, 0), 1);
    directed("R6 weekday", mk(59, 59, 23, 0, 7, 1, 1, 1), 1);
    // R5 12-hour transitions
    directed("R5 11AM to 12PM", mk(59, 59, 11, 1, 1, 1, 1, 1), 1);
    directed("R5 12PM to 1PM", mk(59, 59, 12, 1, 1, 1, 1, 1), 1);
    directed("R5 11PM to 12AM", mk(59, 59, 23, 1, 5, 28, 2, 30), 1);
    directed("R5 12AM to 1AM", mk(59, 59, 0, 1, 5, 1, 1, 1), 1);
    load_all(mk(59, 59, 11, 1, 1, 1, 1, 1));
    run_secs(1);
    check("R5 PM byte", {40'h0, hour_o, 16'h0}, {40'h0, 8'h72, 16'h0});

    // R11 select code 7 changes nothing
    t = mk(20, 30, 6, 0, 2, 14, 8, 44);
    load_all(t);
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd7; wr_data = 8'h33;
    @(negedge clk); wr_en = 1'b0;
    check("R11 code 7", outs(), pack_tm(t));
    // R11 single field loads
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd5; wr_data = 8'h09;
    @(negedge clk); wr_en = 1'b0;
    t.mo = 9;
    check("R11 month load", outs(), pack_tm(t));

    // R10 stopped time holds, loads still land
    osc_off = 1'b1;
    t = mk(59, 59, 23, 0, 7, 31, 12, 99);
    load_all(t);
    run_secs(5);
    check("R10 hold", outs(), pack_tm(t));
    osc_off = 1'b0;
    run_secs(1);
    check("R10 resume", outs(), pack_tm(advance(t, 1)));

    // random valid times in both encodings
    for (int i = 0; i < 40; i++) begin
      tm_t r;
      int n;
      r.h12 = 1'($urandom_range(0, 1));
      r.y  = $urandom_range(0, 99);
      r.mo = $urandom_range(1, 12);
      r.d  = $urandom_range(1, days_of(r.mo, r.y));
      if ($urandom_range(0, 1) == 1) r.d = days_of(r.mo, r.y);
      r.wd = $urandom_range(1, 7);
      r.h  = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      r.m  = $urandom_range(55, 59);
      r.s  = $urandom_range(0, 59);
      n = $urandom_range(1, 400);
      directed(r.h12 ? "R5 random" : "R7 random", r, n);
    end

    finish_run();
  end
endmodule